// File: doc/BRIEF.md
# Configuration Flash Programming Sequencer

This block runs on the host side of an on-chip configuration flash. One start pulse launches the whole job. The block erases the flash and rewinds the page address. It then programs a requested number of 128-bit pages and writes a 32-bit user code. Last, it marks the image as complete and asks the target to reload itself. Every command goes out as a framed byte stream over a valid/ready handshake. A separate transport, such as SPI or I2C, carries the bytes and returns one status byte for each status query.

Program-type commands and erase finish in different ways:

- **Page program, user-code write, completion mark:** the block waits a fixed settle time, counted in clock cycles. It then polls status until the target is idle.
- **Erase:** the block polls status straight away. Erase time varies too much for a fixed wait.

A fail bit in the status byte ends the job with an error. So does a busy bit that does not clear within a bounded number of polls. Page data comes from a feed with its own handshake. The block takes one page just before each program command.

Top module: `flash_seq_top`

## Requirements
- R1: After reset, `cmd_valid_o`, `page_ready_o`, `done_o` and `err_o` are all low.
- R2: Every frame is sent in this order:
  - one opcode byte;
  - three operand bytes of 0x00;
  - any payload, most significant byte first.

  `cmd_last_o` is high only on the final byte of a frame. While `cmd_valid_o` is high and `cmd_ready_i` is low, the byte and the last flag hold still.
- R3: One job sends these frames in order:
  1. erase (0x0E);
  2. address reset (0x46);
  3. for each page, program (0x70) with 16 bytes of page data;
  4. user-code write (0xC2) with 4 bytes of user code;
  5. program-done (0x5E);
  6. refresh (0x79).

  The status query frames of R7 go between them.
- R4: `page_ready_o` is high only while `page_valid_i` is high, exactly once per page. The page count is sampled at start. A count of zero skips page programming.
- R5: After the last byte of a page program, user-code or program-done frame, no byte is presented for at least `DELAY_CYC` clock cycles.
- R6: After the last byte of the erase frame, the first status query byte is presented within two clock cycles. There is no fixed wait.
- R7: Erase, page program, user-code and program-done are each followed by status queries. A query is the frame 0x3C with no payload, and the target answers each query with one `rsp_data_i` byte:
  - bit 0 is busy;
  - bit 1 is fail.

  A busy answer repeats the query. An answer with both bits clear moves on to the next step.
- R8: An answer with the fail bit set and the busy bit clear sets `done_o` and `err_o`, and no further byte is sent.
- R9: `POLL_LIMIT` busy answers in a row within one step set `done_o` and `err_o`, and no further byte is sent.
- R10: After the refresh frame, `done_o` goes high with `err_o` low. Both flags hold until the next accepted start, which clears them.
- R11: A start pulse while a job is running has no effect on the byte stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| num_pages_i | input | PAGE_CNT_W | Number of pages to program |
| user_code_i | input | 32 | User code word written after the pages |
| page_data_i | input | PAGE_BITS | Page data from the feed |
| page_valid_i | input | 1 | Feed has a page ready |
| page_ready_o | output | 1 | Page taken this cycle |
| cmd_byte_o | output | 8 | Command stream byte |
| cmd_valid_o | output | 1 | Byte valid |
| cmd_last_o | output | 1 | Final byte of the frame |
| cmd_ready_i | input | 1 | Transport accepts the byte |
| rsp_data_i | input | 8 | Status answer byte |
| rsp_valid_i | input | 1 | Status answer valid for one cycle |
| done_o | output | 1 | Job ended |
| err_o | output | 1 | Job ended with an error |

## Verification
The bench targets these corner cases:

- **Completion waits.** A sequencer that reused the settle wait after erase would show a gap far longer than two cycles. One that skipped the wait after program-type commands would query status too early.
- **Poll outcomes.** The bench sends busy streaks that end cleanly, streaks that reach the poll limit, and a fail bit in mid-job. An off-by-one poll counter would either give up one query early or send one query too many.
- **Page handling.** The bench covers a page count of zero, stalls on the transport's ready, and a second start pulse during a job. These catch a block that takes a stray page, drops bytes under backpressure, or restarts mid-stream.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam logic [7:0] OP_ERASE   = 8'h0E;
    localparam logic [7:0] OP_ADDR    = 8'h46;
    localparam logic [7:0] OP_PROG    = 8'h70;
    localparam logic [7:0] OP_STATUS  = 8'h3C;
    localparam logic [7:0] OP_UCODE   = 8'hC2;
    localparam logic [7:0] OP_PDONE   = 8'h5E;
    localparam logic [7:0] OP_REFRESH = 8'h79;

    typedef enum logic [2:0] {
        PH_IDLE, PH_TX, PH_PAGE_WAIT, PH_DELAY, PH_POLL_TX, PH_POLL_RX
    } phase_t;

    typedef enum logic [2:0] {
        ST_ERASE, ST_ADDR, ST_PAGE, ST_UCODE, ST_PDONE, ST_REFRESH
    } step_t;

    // program-type steps wait a settle time before polling
    function automatic logic step_waits(input step_t s);
        return (s == ST_PAGE) || (s == ST_UCODE) || (s == ST_PDONE);
    endfunction

    // steps whose completion is confirmed by status polling
    function automatic logic step_polls(input step_t s);
        return (s == ST_ERASE) || step_waits(s);
    endfunction

    function automatic logic [7:0] step_opcode(input step_t s);
        case (s)
            ST_ERASE:   return OP_ERASE;
            ST_ADDR:    return OP_ADDR;
            ST_PAGE:    return OP_PROG;
            ST_UCODE:   return OP_UCODE;
            ST_PDONE:   return OP_PDONE;
            default:    return OP_REFRESH;
        endcase
    endfunction

endpackage

// File: rtl/flash_seq_delay.sv
module flash_seq_delay #(
    parameter int CYC = 25000,
    localparam int CW = $clog2(CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic expired_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)
            cnt_d = CW'(CYC);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/flash_seq_ser.sv
module flash_seq_ser #(
    parameter int BYTES = 20,
    localparam int LW = $clog2(BYTES + 1),
    localparam int FW = BYTES * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [FW-1:0] frame_i,
    input  logic [LW-1:0] len_i,
    output logic [7:0]    byte_o,
    output logic          valid_o,
    output logic          last_o,
    input  logic          ready_i,
    output logic          idle_o
);
    logic [FW-1:0] sh_d, sh_q;
    logic [LW-1:0] cnt_d, cnt_q;

    always_comb begin
        sh_d  = sh_q;
        cnt_d = cnt_q;
        if (load_i) begin
            sh_d  = frame_i;
            cnt_d = len_i;
        end else if (cnt_q != '0 && ready_i) begin
            sh_d  = sh_q << 8;
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else begin
            sh_q  <= sh_d;
            cnt_q <= cnt_d;
        end
    end

    assign byte_o  = sh_q[FW-1 -: 8];
    assign valid_o = (cnt_q != '0);
    assign last_o  = (cnt_q == LW'(1));
    assign idle_o  = (cnt_q == '0);
endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
    import flash_seq_pkg::*;
#(
    parameter int PAGE_BITS  = 128,
    parameter int PAGE_CNT_W = 8,
    parameter int DELAY_CYC  = 25000,
    parameter int POLL_LIMIT = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [PAGE_CNT_W-1:0] num_pages_i,
    input  logic [31:0]           user_code_i,
    input  logic [PAGE_BITS-1:0]  page_data_i,
    input  logic                  page_valid_i,
    output logic                  page_ready_o,
    output logic [7:0]            cmd_byte_o,
    output logic                  cmd_valid_o,
    output logic                  cmd_last_o,
    input  logic                  cmd_ready_i,
    input  logic [7:0]            rsp_data_i,
    input  logic                  rsp_valid_i,
    output logic                  done_o,
    output logic                  err_o
);
    localparam int FRAME_BYTES = 4 + PAGE_BITS / 8;
    localparam int FRAME_W     = FRAME_BYTES * 8;
    localparam int LEN_W       = $clog2(FRAME_BYTES + 1);
    localparam int POLL_W      = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        phase_t                ph;
        step_t                 st;
        logic [PAGE_CNT_W-1:0] pages_left;
        logic [31:0]           ucode;
        logic [POLL_W-1:0]     polls;
        logic                  done;
        logic                  err;
    } seq_t;

    seq_t d, q;

    logic               ld, tmr_start, tmr_expired, ser_idle;
    logic [FRAME_W-1:0] frame;
    logic [LEN_W-1:0]   len;

    function automatic logic [FRAME_W-1:0] hdr(input logic [7:0] op);
        return {op, 24'h0, {PAGE_BITS{1'b0}}};
    endfunction

    always_comb begin
        logic  advance, go, fail;
        step_t go_st;
        d            = q;
        ld           = 1'b0;
        frame        = '0;
        len          = '0;
        tmr_start    = 1'b0;
        page_ready_o = 1'b0;
        advance      = 1'b0;
        go           = 1'b0;
        fail         = 1'b0;
        go_st        = ST_ERASE;

        case (q.ph)
            PH_IDLE: if (start_i) begin
                d.pages_left = num_pages_i;
                d.ucode      = user_code_i;
                d.done       = 1'b0;
                d.err        = 1'b0;
                go           = 1'b1;
                go_st        = ST_ERASE;
            end
            PH_PAGE_WAIT: if (page_valid_i) begin
                page_ready_o = 1'b1;
                ld           = 1'b1;
                frame        = {OP_PROG, 24'h0, page_data_i};
                len          = LEN_W'(FRAME_BYTES);
                d.pages_left = q.pages_left - 1'b1;
                d.ph         = PH_TX;
            end
            PH_TX: if (ser_idle) begin
                if (step_waits(q.st)) begin
                    tmr_start = 1'b1;
                    d.ph      = PH_DELAY;
                end else if (step_polls(q.st)) begin
                    ld      = 1'b1;
                    frame   = hdr(OP_STATUS);
                    len     = LEN_W'(4);
                    d.polls = '0;
                    d.ph    = PH_POLL_TX;
                end else begin
                    advance = 1'b1;
                end
            end
            PH_DELAY: if (tmr_expired) begin
                ld      = 1'b1;
                frame   = hdr(OP_STATUS);
                len     = LEN_W'(4);
                d.polls = '0;
                d.ph    = PH_POLL_TX;
            end
            PH_POLL_TX: if (ser_idle) d.ph = PH_POLL_RX;
            PH_POLL_RX: if (rsp_valid_i) begin
                if (rsp_data_i[0]) begin
                    if (q.polls == POLL_W'(POLL_LIMIT - 1)) begin
                        fail = 1'b1;
                    end else begin
                        d.polls = q.polls + 1'b1;
                        ld      = 1'b1;
                        frame   = hdr(OP_STATUS);
                        len     = LEN_W'(4);
                        d.ph    = PH_POLL_TX;
                    end
                end else if (rsp_data_i[1]) begin
                    fail = 1'b1;
                end else begin
                    advance = 1'b1;
                end
            end
            default: d.ph = PH_IDLE;
        endcase

        if (advance) begin
            case (q.st)
                ST_ERASE: begin go = 1'b1; go_st = ST_ADDR; end
                ST_ADDR, ST_PAGE: begin
                    go    = 1'b1;
                    go_st = (q.pages_left != '0) ? ST_PAGE : ST_UCODE;
                end
                ST_UCODE: begin go = 1'b1; go_st = ST_PDONE; end
                ST_PDONE: begin go = 1'b1; go_st = ST_REFRESH; end
                default: begin
                    d.ph   = PH_IDLE;
                    d.done = 1'b1;
                end
            endcase
        end

        if (go) begin
            d.st = go_st;
            if (go_st == ST_PAGE) begin
                d.ph = PH_PAGE_WAIT;
            end else begin
                ld    = 1'b1;
                d.ph  = PH_TX;
                frame = hdr(step_opcode(go_st));
                len   = LEN_W'(4);
                if (go_st == ST_UCODE) begin
                    frame = frame | (FRAME_W'(d.ucode) << (PAGE_BITS - 32));
                    len   = LEN_W'(8);
                end
            end
        end

        if (fail) begin
            d.ph   = PH_IDLE;
            d.done = 1'b1;
            d.err  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ph         <= PH_IDLE;
            q.st         <= ST_ERASE;
            q.pages_left <= '0;
            q.ucode      <= '0;
            q.polls      <= '0;
            q.done       <= 1'b0;
            q.err        <= 1'b0;
        end else begin
            q <= d;
        end
    end

    flash_seq_ser #(.BYTES(FRAME_BYTES)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (ld),
        .frame_i (frame),
        .len_i   (len),
        .byte_o  (cmd_byte_o),
        .valid_o (cmd_valid_o),
        .last_o  (cmd_last_o),
        .ready_i (cmd_ready_i),
        .idle_o  (ser_idle)
    );

    flash_seq_delay #(.CYC(DELAY_CYC)) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (tmr_start),
        .expired_o (tmr_expired)
    );

    assign done_o = q.done;
    assign err_o  = q.err;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
    parameter int DELAY_CYC = 25000,
    localparam int GW = $clog2(DELAY_CYC + 1)
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cmd_byte_o,
    input logic       cmd_valid_o,
    input logic       cmd_last_o,
    input logic       cmd_ready_i,
    input logic       page_valid_i,
    input logic       page_ready_o,
    input logic       done_o,
    input logic       err_o
);
    logic          hs;
    logic          in_frame_q, prog_q;
    logic [7:0]    op_q;
    logic [GW-1:0] gap_q;

    assign hs = cmd_valid_o && cmd_ready_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            prog_q     <= 1'b0;
            op_q       <= '0;
            gap_q      <= '0;
        end else begin
            if (gap_q != GW'(DELAY_CYC)) gap_q <= gap_q + 1'b1;
            if (hs && !in_frame_q) begin
                op_q       <= cmd_byte_o;
                in_frame_q <= 1'b1;
                prog_q     <= 1'b0;
            end
            if (hs && cmd_last_o) begin
                in_frame_q <= 1'b0;
                gap_q      <= '0;
                prog_q     <= (op_q == 8'h70) || (op_q == 8'hC2) || (op_q == 8'h5E);
            end
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_byte_o) && $stable(cmd_last_o));

    assert_page_hs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        page_ready_o |-> page_valid_i);

    assert_prog_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
        page_ready_o |=> cmd_valid_o && cmd_byte_o == 8'h70);

    assert_erase_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> cmd_valid_o && cmd_byte_o == 8'h0E);

    assert_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hs && !in_frame_q && prog_q |-> gap_q >= GW'(DELAY_CYC));

    assert_err_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !cmd_valid_o);
endmodule

bind flash_seq_top flash_seq_chk #(.DELAY_CYC(DELAY_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_byte_o   (cmd_byte_o),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_last_o   (cmd_last_o),
    .cmd_ready_i  (cmd_ready_i),
    .page_valid_i (page_valid_i),
    .page_ready_o (page_ready_o),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/flash_seq_top_tb_top.sv
module flash_seq_top_tb_top;
    localparam int PB  = 128;
    localparam int CW  = 4;
    localparam int DLY = 30;
    localparam int PL  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [CW-1:0] num_pages_i = '0;
    logic [31:0]   user_code_i = '0;
    logic [PB-1:0] page_data_i = '0;
    logic          page_valid_i = 1'b0;
    logic          page_ready_o;
    logic [7:0]    cmd_byte_o;
    logic          cmd_valid_o, cmd_last_o;
    logic          cmd_ready_i = 1'b0;
    logic [7:0]    rsp_data_i = '0;
    logic          rsp_valid_i = 1'b0;
    logic          done_o, err_o;

    always #4 clk = ~clk;

    flash_seq_top #(.PAGE_BITS(PB), .PAGE_CNT_W(CW), .DELAY_CYC(DLY), .POLL_LIMIT(PL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .num_pages_i(num_pages_i),
        .user_code_i(user_code_i), .page_data_i(page_data_i), .page_valid_i(page_valid_i),
        .page_ready_o(page_ready_o), .cmd_byte_o(cmd_byte_o), .cmd_valid_o(cmd_valid_o),
        .cmd_last_o(cmd_last_o), .cmd_ready_i(cmd_ready_i), .rsp_data_i(rsp_data_i),
        .rsp_valid_i(rsp_valid_i), .done_o(done_o), .err_o(err_o)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit [8:0]      exp_q[$];
    bit [7:0]      mdl_st[$], rsp_q[$];
    logic [PB-1:0] pages[$];
    bit            exp_err, stall_en, pend, wait_first;
    int            exp_pages, pg_idx, pg_taken, rsp_cnt, t_last;
    bit [7:0]      cur_op, last_op;
    bit            in_frame;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    task automatic put(input bit [7:0] b, input bit last);
        exp_q.push_back({last, b});
    endtask
    task automatic hdr(input bit [7:0] op, input bit has_payload);
        put(op, 1'b0); put(8'h00, 1'b0); put(8'h00, 1'b0); put(8'h00, !has_payload);
    endtask
    task automatic model_poll(output bit ok);
        int busy = 0;
        bit [7:0] s;
        ok = 1'b0;
        forever begin
            hdr(8'h3C, 1'b0);
            s = (mdl_st.size() != 0) ? mdl_st.pop_front() : 8'h00;
            if (s[0]) begin
                busy++;
                if (busy == PL) return;
            end else begin
                ok = !s[1];
                return;
            end
        end
    endtask
    task automatic model(input int n, input logic [31:0] uc);
        bit ok;
        exp_q.delete(); exp_err = 1'b1; exp_pages = 0;
        hdr(8'h0E, 1'b0); model_poll(ok); if (!ok) return;
        hdr(8'h46, 1'b0);
        for (int i = 0; i < n; i++) begin
            exp_pages++;
            hdr(8'h70, 1'b1);
            for (int b = PB/8 - 1; b >= 0; b--) put(pages[i][b*8 +: 8], b == 0);
            model_poll(ok); if (!ok) return;
        end
        hdr(8'hC2, 1'b1);
        for (int b = 3; b >= 0; b--) put(uc[b*8 +: 8], b == 0);
        model_poll(ok); if (!ok) return;
        hdr(8'h5E, 1'b0); model_poll(ok); if (!ok) return;
        hdr(8'h79, 1'b0);
        exp_err = 1'b0;
    endtask

    // ---------------- per-clock target and comparison ----------------
    always @(negedge clk) begin
        bit pr, r;
        bit [8:0] e;
        if (rst_n) begin
            cyc++;
            if (cmd_valid_o && wait_first) begin
                wait_first = 1'b0;
                if (last_op == 8'h70 || last_op == 8'hC2 || last_op == 8'h5E)
                    chk(cyc - t_last >= DLY, "R5 settle gap", cyc - t_last, DLY);
                if (last_op == 8'h0E)
                    chk(cyc - t_last <= 2, "R6 erase poll gap", cyc - t_last, 2);
            end
            pr = page_ready_o;
            if (pend) begin
                pend = 1'b0;
                pg_idx++;
                page_valid_i = (pg_idx < pages.size());
                page_data_i  = (pg_idx < pages.size()) ? pages[pg_idx] : '0;
            end
            if (pr) begin pend = 1'b1; pg_taken++; end

            r = !(stall_en && (cyc % 3 == 1));
            cmd_ready_i = r;
            if (cmd_valid_o && r) begin
                e = (exp_q.size() != 0) ? exp_q.pop_front() : 9'h1FF;
                chk(e[7:0] == cmd_byte_o, "R3 byte", cmd_byte_o, e[7:0]);
                chk(e[8] == cmd_last_o, "R2 last flag", cmd_last_o, e[8]);
                if (!in_frame) begin cur_op = cmd_byte_o; in_frame = 1'b1; end
                if (cmd_last_o) begin
                    in_frame = 1'b0; last_op = cur_op; t_last = cyc; wait_first = 1'b1;
                    if (cur_op == 8'h3C) rsp_cnt = 3;
                end
            end
            rsp_valid_i = 1'b0;
            if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    rsp_valid_i = 1'b1;
                    rsp_data_i  = (rsp_q.size() != 0) ? rsp_q.pop_front() : 8'h00;
                end
            end
        end
    end

    task automatic run(input int n, input logic [31:0] uc, input bit [7:0] st[$],
                       input bit stall, input bit restart, input string tag);
        pages.delete();
        for (int i = 0; i < n; i++)
            pages.push_back({4{32'h1000_0000 * (i + 1) + 32'h0102_0304 * (i + 7)}});
        mdl_st = st; rsp_q = st;
        model(n, uc);
        @(negedge clk);
        stall_en = stall; pg_idx = 0; pg_taken = 0; pend = 1'b0;
        page_valid_i = (n > 0); page_data_i = (n > 0) ? pages[0] : '0;
        num_pages_i = CW'(n); user_code_i = uc; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0 && err_o == 1'b0, {tag, " R10 flags cleared on start"}, {done_o, err_o}, 0);
        if (restart) begin
            repeat (40) @(negedge clk);
            start_i = 1'b1; num_pages_i = '0;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " R3 stream complete"}, exp_q.size(), 0);
        chk(err_o == exp_err, {tag, " R7 R8 R9 error flag"}, err_o, exp_err);
        chk(done_o == 1'b1, {tag, " R10 done held"}, done_o, 1);
        chk(pg_taken == exp_pages, {tag, " R4 pages taken"}, pg_taken, exp_pages);
        chk(cmd_valid_o == 1'b0, {tag, " R8 quiet after end"}, cmd_valid_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cmd_valid_o == 0 && page_ready_o == 0 && done_o == 0 && err_o == 0,
            "R1 reset state", {cmd_valid_o, page_ready_o, done_o, err_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R7 busy streaks that clear, R11 second start ignored
        run(2, 32'hCAFE_1234, '{8'h01, 8'h01, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00}, 1'b0, 1'b1, "A");
        // R4 zero pages, R2 under backpressure
        run(0, 32'h0BAD_F00D, '{8'h00, 8'h01, 8'h00, 8'h00}, 1'b1, 1'b0, "B");
        // R8 fail bit on first page
        run(3, 32'h1111_2222, '{8'h00, 8'h02}, 1'b1, 1'b0, "C");
        // R9 poll limit on erase
        run(1, 32'h3333_4444, '{8'h01, 8'h01, 8'h01, 8'h01, 8'h01}, 1'b0, 1'b0, "D");
        // R9 one short of the limit still passes
        run(1, 32'h5555_6666, '{8'h00, 8'h01, 8'h01, 8'h01, 8'h00}, 1'b0, 1'b0, "E");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule